// File: doc/BRIEF.md
# Dual-Mode Multiplexed Host Bus Port

This block connects a host processor to a 128-location byte space over a single 8-bit bus that carries an address first and data afterwards. An address strobe captures the location; a data strobe then moves one byte in or out. A static strap input picks one of two strobe conventions. In the Motorola-style convention, a high data strobe qualifies the transfer and the read/write line gives its direction. In the Intel-style convention, the data strobe is an active-low read and the read/write line is an active-low write.

The lowest 14 locations belong to the clock and control registers, which sit outside this block. Writes to them leave through a one-cycle write port, and reads take the byte that the register file returns. The remaining 114 locations are held in storage inside the block. A low reset returns the bus logic to idle but does not touch stored bytes.

All bus pins are sampled on the system clock, so strobes are treated as slow, synchronous levels. Read data is driven through a separate output enable, one cycle after the read qualifies.

Top module: `dual_strobe_bus_if`

## Requirements
- R1: On a high-to-low change of `addrStrb`, bits 6:0 of `adIn` become the current location and bit 7 is ignored, so location 0x80+n selects the same byte as n.
- R2: With `motoMode`=1, a cycle sampled with `dataStrb`=1 and `rwN`=1 is a read: `adOe` is 1 one cycle later and `adOut` carries the byte at the current location.
- R3: With `motoMode`=1, a write commits on the cycle where `dataStrb` is sampled 0 after a cycle with `dataStrb`=1 and `rwN`=0, and stores the `adIn` value of that earlier cycle.
- R4: With `motoMode`=0, a cycle sampled with `dataStrb`=0 is a read and behaves as in R2.
- R5: With `motoMode`=0, a write commits on the cycle where `rwN` is sampled 1 after a cycle with `rwN`=0, and stores the `adIn` value of that earlier cycle.
- R6: Writes to locations 0 to 13 raise `ctlWrEn` for exactly one cycle, with `ctlAddr` equal to the location and `ctlWrData` equal to the byte. Reads from those locations return `ctlRdData`.
- R7: Locations 14 to 127 are internal storage: a read returns the last byte written there, and a write to them never raises `ctlWrEn`.
- R8: `adOe` is 0 one cycle after any cycle in which no read qualifies.
- R9: While `rstN` is 0, `adOe` and `ctlWrEn` are 0 and the current location is cleared to 0. Bytes in storage keep their values across reset.
- R10: With `motoMode`=1, toggling `rwN` while `dataStrb` stays 0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rstN | input | 1 | Active-low reset of bus logic |
| motoMode | input | 1 | Strap: 1 selects Motorola-style strobes, 0 selects Intel-style strobes |
| addrStrb | input | 1 | Address strobe; location is captured on its falling edge |
| dataStrb | input | 1 | Data strobe: high qualifier (Motorola-style) or active-low read (Intel-style) |
| rwN | input | 1 | Direction (1 read, 0 write) or active-low write strobe |
| adIn | input | 8 | Multiplexed address/data bus, input side |
| adOut | output | 8 | Read data, valid while adOe is 1 |
| adOe | output | 1 | Output enable for the bus drivers |
| ctlWrEn | output | 1 | One-cycle write pulse to the control register file |
| ctlAddr | output | 4 | Control register index |
| ctlWrData | output | 8 | Byte written to the control register file |
| ctlRdData | input | 8 | Byte returned by the control register file for the current location |

## Verification
The bench runs the same traffic under both strap settings. A design with the write polarity swapped in one convention stores nothing, or stores bytes during reads, and the read-back comparison catches it. It also writes through the aliased upper half of the address (bit 7 set), so a design that decodes bit 7 lands outside storage and returns stale data. Writes at locations 13 and 14 test the control/storage split: an off-by-one boundary sends a byte the wrong way, which either gives an unexpected write pulse or loses a byte. A reset between a storage write and its read-back shows whether storage is wrongly cleared, and a read with no new address phase shows whether the current location was cleared.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  // Per-cycle strobes from bus control to the datapath
  typedef struct packed {
    logic latchAddr;  // capture location from the bus
    logic writeStb;   // commit held byte to current location
    logic readEn;     // present current location on the bus next cycle
  } busStrobes_t;
endpackage

// File: rtl/dsb_ctrl.sv
module dsb_ctrl
  import dsb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        motoMode,
  input  logic        addrStrb,
  input  logic        dataStrb,
  input  logic        rwN,
  output busStrobes_t stb
);
  logic prevAs, prevDs, prevRw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAs <= 1'b0;
      prevDs <= 1'b0;
      prevRw <= 1'b1;
    end else begin
      prevAs <= addrStrb;
      prevDs <= dataStrb;
      prevRw <= rwN;
    end
  end

  always_comb begin
    stb.latchAddr = prevAs & ~addrStrb;
    if (motoMode) begin
      stb.readEn   = dataStrb & rwN;
      stb.writeStb = prevDs & ~dataStrb & ~prevRw;
    end else begin
      stb.readEn   = ~dataStrb;
      stb.writeStb = ~prevRw & rwN;
    end
  end
endmodule

// File: rtl/dsb_dpath.sv
module dsb_dpath
  import dsb_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int CTL_BYTES = 14,
  localparam int CTL_AW      = $clog2(CTL_BYTES),
  localparam int STORE_BYTES = (1 << ADDR_W) - CTL_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       stb,
  input  logic [DATA_W-1:0] adIn,
  input  logic [DATA_W-1:0] ctlRdData,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              ctlWrEn,
  output logic [CTL_AW-1:0] ctlAddr,
  output logic [DATA_W-1:0] ctlWrData
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataHold;
  logic [DATA_W-1:0] store [STORE_BYTES];
  logic              isCtl;
  logic [ADDR_W-1:0] storeIdx;

  assign isCtl    = addrReg < ADDR_W'(CTL_BYTES);
  assign storeIdx = addrReg - ADDR_W'(CTL_BYTES);

  // Bus value of the last cycle, used when a write strobe ends
  always_ff @(posedge clk) dataHold <= adIn;

  // Storage has no reset: contents survive rstN
  always_ff @(posedge clk) begin
    if (stb.writeStb && !isCtl) store[storeIdx] <= dataHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      adOe      <= 1'b0;
      adOut     <= '0;
      ctlWrEn   <= 1'b0;
      ctlAddr   <= '0;
      ctlWrData <= '0;
    end else begin
      if (stb.latchAddr) addrReg <= adIn[ADDR_W-1:0];
      adOe    <= stb.readEn;
      ctlWrEn <= stb.writeStb && isCtl;
      if (stb.readEn) adOut <= isCtl ? ctlRdData : store[storeIdx];
      if (stb.writeStb && isCtl) begin
        ctlAddr   <= addrReg[CTL_AW-1:0];
        ctlWrData <= dataHold;
      end
    end
  end
endmodule

// File: rtl/dual_strobe_bus_if.sv
module dual_strobe_bus_if
  import dsb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       motoMode,
  input  logic       addrStrb,
  input  logic       dataStrb,
  input  logic       rwN,
  input  logic [7:0] adIn,
  output logic [7:0] adOut,
  output logic       adOe,
  output logic       ctlWrEn,
  output logic [3:0] ctlAddr,
  output logic [7:0] ctlWrData,
  input  logic [7:0] ctlRdData
);
  busStrobes_t stb;

  dsb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .motoMode(motoMode), .addrStrb(addrStrb),
    .dataStrb(dataStrb), .rwN(rwN), .stb(stb)
  );

  dsb_dpath #(.ADDR_W(7), .DATA_W(8), .CTL_BYTES(14)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .adIn(adIn), .ctlRdData(ctlRdData),
    .adOut(adOut), .adOe(adOe), .ctlWrEn(ctlWrEn), .ctlAddr(ctlAddr),
    .ctlWrData(ctlWrData)
  );
endmodule

// File: rtl/dsb_chk.sv
module dsb_chk (
  input logic       clk,
  input logic       rstN,
  input logic       motoMode,
  input logic       dataStrb,
  input logic       rwN,
  input logic       adOe,
  input logic       ctlWrEn,
  input logic [3:0] ctlAddr
);
  logic rdQual;
  assign rdQual = motoMode ? (dataStrb & rwN) : ~dataStrb;

  // R2
  read_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdQual |=> adOe);

  // R8
  idle_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdQual |=> !adOe);

  // R6
  ctl_index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |-> ctlAddr < 4'd14);

  // R6
  ctl_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> !ctlWrEn);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!adOe && !ctlWrEn));
endmodule

bind dual_strobe_bus_if dsb_chk u_chk (
  .clk(clk), .rstN(rstN), .motoMode(motoMode), .dataStrb(dataStrb),
  .rwN(rwN), .adOe(adOe), .ctlWrEn(ctlWrEn), .ctlAddr(ctlAddr)
);

// File: tb/sim_dual_strobe_bus_if.sv
module sim_dual_strobe_bus_if;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       motoMode = 1'b1;
  logic       addrStrb = 1'b0;
  logic       dataStrb = 1'b0;
  logic       rwN = 1'b1;
  logic [7:0] adIn = '0;
  logic [7:0] ctlRdData = '0;
  logic [7:0] adOut;
  logic       adOe;
  logic       ctlWrEn;
  logic [3:0] ctlAddr;
  logic [7:0] ctlWrData;

  int cmpCount = 0;
  int badCount = 0;
  bit done = 1'b0;

  logic [7:0]  rdQ [$];
  string       rdTag [$];
  logic [11:0] ctlQ [$];
  logic        oePrev = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dual_strobe_bus_if u0 (
    .clk(clk), .rstN(rstN), .motoMode(motoMode), .addrStrb(addrStrb),
    .dataStrb(dataStrb), .rwN(rwN), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .ctlWrEn(ctlWrEn), .ctlAddr(ctlAddr), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    cmpCount++;
    if (act !== exp) begin
      badCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCount, badCount);
      $finish;
    end
  endtask

  // Monitor: compares reads and control writes as they appear
  always @(negedge clk) begin
    if (rstN) begin
      if (adOe && !oePrev) begin
        if (rdQ.size() == 0) check("R2/R4 unexpected read", {4'h0, adOut}, 12'hFFF);
        else check(rdTag.pop_front(), {4'h0, adOut}, {4'h0, rdQ.pop_front()});
      end
      if (ctlWrEn) begin
        if (ctlQ.size() == 0) check("R7 unexpected ctlWrEn", {ctlAddr, ctlWrData}, 12'hFFF);
        else check("R6 control write", {ctlAddr, ctlWrData}, ctlQ.pop_front());
      end
    end
    oePrev = adOe;
  end

  task automatic setMode(input logic moto);
    @(negedge clk);
    motoMode = moto;
    dataStrb = moto ? 1'b0 : 1'b1;
    rwN = 1'b1;
  endtask

  task automatic addrPhase(input logic [7:0] a);
    @(negedge clk); addrStrb = 1'b1; adIn = a;
    @(negedge clk); addrStrb = 1'b0;
    @(negedge clk); adIn = 8'h00;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    addrPhase(a);
    if (a[6:0] < 7'd14) ctlQ.push_back({a[3:0], d});
    @(negedge clk); adIn = d; rwN = 1'b0;
    if (motoMode) dataStrb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (motoMode) dataStrb = 1'b0; else rwN = 1'b1;
    @(negedge clk); rwN = 1'b1; adIn = 8'h00;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [7:0] a, input bit doAddr,
                         input logic [7:0] exp, input string tag);
    if (doAddr) addrPhase(a);
    rdQ.push_back(exp); rdTag.push_back(tag);
    @(negedge clk); dataStrb = motoMode ? 1'b1 : 1'b0; rwN = 1'b1;
    @(negedge clk);
    @(negedge clk); dataStrb = motoMode ? 1'b0 : 1'b1;
    @(negedge clk);
    check("R8 adOe released", {11'h0, adOe}, 12'h000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    badCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset adOe", {11'h0, adOe}, 12'h000);
    check("R9 reset ctlWrEn", {11'h0, ctlWrEn}, 12'h000);
    rstN = 1'b1;

    // Motorola-style convention
    setMode(1'b1);
    busWrite(8'd20, 8'h5A);
    busRead(8'd20, 1'b1, 8'h5A, "R3/R2 moto storage");
    busWrite(8'd127, 8'hC3);
    busRead(8'd127, 1'b1, 8'hC3, "R7 top of storage");
    busWrite(8'd14, 8'h11);
    busRead(8'd14, 1'b1, 8'h11, "R7 first storage byte");
    busWrite(8'd13, 8'h77);
    busWrite(8'd0, 8'h01);
    ctlRdData = 8'h9D;
    busRead(8'd5, 1'b1, 8'h9D, "R6 control read moto");
    busWrite(8'h80 | 8'd30, 8'hE4);
    busRead(8'd30, 1'b1, 8'hE4, "R1 bit7 alias");
    // R10: rwN pulses without data strobe
    addrPhase(8'd20);
    @(negedge clk); adIn = 8'hFF; rwN = 1'b0;
    @(negedge clk); rwN = 1'b1;
    @(negedge clk); rwN = 1'b0;
    @(negedge clk); rwN = 1'b1; adIn = 8'h00;
    busRead(8'd20, 1'b0, 8'h5A, "R10 no write without strobe");

    // Intel-style convention
    setMode(1'b0);
    busWrite(8'd40, 8'h3C);
    busRead(8'd40, 1'b1, 8'h3C, "R5/R4 intel storage");
    busRead(8'd127, 1'b1, 8'hC3, "R4 intel reads earlier write");
    busWrite(8'd9, 8'hA5);
    ctlRdData = 8'h62;
    busRead(8'd9, 1'b1, 8'h62, "R6 control read intel");
    busWrite(8'h80 | 8'd100, 8'h4B);
    busRead(8'd100, 1'b1, 8'h4B, "R1 intel alias");

    // R9: reset keeps storage, clears current location
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R9 reset adOe mid-run", {11'h0, adOe}, 12'h000);
    check("R9 reset ctlWrEn mid-run", {11'h0, ctlWrEn}, 12'h000);
    @(negedge clk); rstN = 1'b1;
    ctlRdData = 8'hA7;
    busRead(8'd0, 1'b0, 8'hA7, "R9 location cleared");
    busRead(8'd40, 1'b1, 8'h3C, "R9 storage retained");

    repeat (4) @(negedge clk);
    check("R7 pending control writes", 12'(ctlQ.size()), 12'h000);
    check("R2 pending reads", 12'(rdQ.size()), 12'h000);
    summary();
  end
endmodule